// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is a two-wire serial bus target that fronts a 512-byte storage array. A master writes it by sending a write-type device address, an 8-bit word address and any number of data bytes. It reads it in one of three ways:

- a current-address read, which continues from where the last operation stopped;
- a selective read, which is a dummy write of the word address followed by a repeated START and a read-type device address;
- a sequential read, in which the master acknowledges each byte to get the next one.

The 9-bit location is built from two parts. One bit of the device address byte supplies the top address bit. A persistent 8-bit internal latch supplies the low byte. After every byte transferred, the whole 9-bit pointer advances by one.

Both bus lines are oversampled in the single system clock domain. The data line is driven only by pulling it low through an output enable. The target recognises every valid way a master may end a read, and lets go of the data line in each of them.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is held and after it is released, the data-line pull-down enable `sda_oe_o` is low.
- R2: The target acknowledges a device address byte only when its bits 7..4 equal 4'b1010. For any other value it gives no acknowledge. It then neither writes memory nor pulls the data line until the next START.
- R3: In a device address with bit 0 = 0, the first following byte loads the low 8 address bits. Each later byte is acknowledged, stored at the current 9-bit address, and the address then advances by one.
- R4: Bit 1 of the device address byte becomes address bit 8 for that transfer. The same word address on page 0 and on page 1 holds independent bytes.
- R5: A write-type address and word address, followed by a repeated START and a read-type address (bit 0 = 1), returns the byte at the chosen location. The first data bit is on the line in the clock right after the address acknowledge.
- R6: A read that starts directly with a read-type address returns the byte that follows the last byte transferred by the previous operation.
- R7: When the master acknowledges a read byte (data low in the 9th clock), the target sends the byte at the next address.
- R8: The 9-bit address advances from 0x1FF to 0x000.
- R9: A read ends cleanly in four ways: no acknowledge followed by STOP, no acknowledge followed by START, STOP in the 9th clock position, or START in the 9th clock position. In each case the line is released, the address has still advanced past the byte just sent, and the next transaction works.
- R10: `sda_oe_o` changes only while the clock line is low.
- R11: A START or STOP seen at any point aborts the transfer in progress. A partly received data byte is not stored, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High to pull the data line low |

## Verification
The bench goes after the read endings that a naive target gets wrong. If the target ignores a STOP or START in the 9th clock position, it keeps shifting bits and fights the master on the bus. If it advances the pointer only on master acknowledge, the following current-address read returns the same byte again.

A sequential read across 0x1FF shows whether the page bit takes part in the increment. A design that wrapped only the low latch would return page-1 data instead of the byte at 0x000.

A mismatched device code followed by data bytes shows a target that does not stay quiet: it would write memory or acknowledge. A STOP in the middle of a data byte shows a target that commits partial bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // bus free, waiting for START
    ST_ADDR,   // shifting in device address byte
    ST_AACK,   // driving acknowledge of the device address
    ST_WORD,   // shifting in word address byte
    ST_DATA,   // shifting in a write data byte
    ST_WACK,   // driving acknowledge of a written byte
    ST_RDAT,   // driving a read byte
    ST_RACK,   // master acknowledge slot of a read byte
    ST_SKIP    // not addressed / read finished, wait for START
  } st_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr_q, sda_sr_q;
  logic              scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr_q <= '1;
      sda_sr_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_i};
      sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_i};
      scl_d_q  <= scl_sr_q[STAGES-1];
      sda_d_q  <= sda_sr_q[STAGES-1];
    end
  end

  assign scl_o    = scl_sr_q[STAGES-1];
  assign sda_o    = sda_sr_q[STAGES-1];
  assign scl_rise = scl_o & ~scl_d_q;
  assign scl_fall = ~scl_o & scl_d_q;
  assign start_o  = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o   = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int         ADDR_W   = 9,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         PAGE_BIT = 1,
  parameter int         SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2cm_pkg::*;

  localparam int BYTE_W = 8;
  localparam int LAT_W  = ADDR_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  st_e               state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rw_q, rw_d, mack_q, mack_d, oe_q, oe_d, we;
  logic [BYTE_W-1:0] rdata;

  i2cm_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(we), .waddr(addr_q), .wdata(sh_q),
    .raddr(addr_q), .rdata(rdata)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    we      = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WORD, ST_DATA: begin
          if (scl_rise && bit_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == FULL) begin
            bit_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1 -: 4] == DEV_CODE) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                addr_d  = {sh_q[PAGE_BIT], addr_q[LAT_W-1:0]};
                state_d = ST_AACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (state_q == ST_WORD) begin
              addr_d[LAT_W-1:0] = sh_q;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end else begin
              we      = 1'b1;
              addr_d  = addr_q + 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WORD;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bit_d   = '0;
            state_d = ST_DATA;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == LAST) begin
              oe_d    = 1'b0;
              addr_d  = addr_q + 1'b1;
              state_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
              bit_d   = '0;
              state_d = ST_RDAT;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2cm_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input st_e  state_q,
  input logic sda_oe_o
);
  always @(posedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!sda_oe_o);
  end

  assert_stable_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  assert_release_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  assert_quiet_when_skipping_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP && $past(state_q == ST_SKIP)) |-> !sda_oe_o);
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .state_q(state_q),
  .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
  localparam int Q = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  int   n_chk = 0, n_fail = 0, r10_viol = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_mem_target u_dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl),
                        .sda_i(sda_bus), .sda_oe_o(sda_oe));

  // R10 monitor: enable must not move while the clock line stays high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_oe != prev_oe) r10_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  // {page, word address, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h10, 8'hA5}, {1'b1, 8'h10, 8'h5A}, {1'b1, 8'hFE, 8'h11},
    {1'b1, 8'hFF, 8'h22}, {1'b0, 8'h00, 8'h33}, {1'b0, 8'h01, 8'h44},
    {1'b0, 8'h80, 8'hC3}, {1'b1, 8'h7F, 8'h96}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bstop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_bus; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    rbits(d);
    send_bit(~mack);
  endtask

  function automatic logic [7:0] sa(input logic page, input logic rd);
    return {4'b1010, 2'b00, page, rd};
  endfunction

  // dummy write of word address then repeated START with read address
  task automatic sel_read(input logic page, input logic [7:0] word, input string req);
    logic a;
    bstart(); wbyte(sa(page, 1'b0), a); chk(req, a, 1);
    wbyte(word, a); chk(req, a, 1);
    bstart(); wbyte(sa(page, 1'b1), a); chk(req, a, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1", sda_oe, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", sda_oe, 0);

    // table: single-byte writes, then selective read-back (R3, R4, R5)
    for (int i = 0; i < 8; i++) begin
      bstart(); wbyte(sa(VEC[i][16], 1'b0), a); chk("R3", a, 1);
      wbyte(VEC[i][15:8], a); chk("R3", a, 1);
      wbyte(VEC[i][7:0], a); chk("R3", a, 1);
      bstop();
    end
    for (int i = 0; i < 8; i++) begin
      sel_read(VEC[i][16], VEC[i][15:8], "R5");
      rbyte(d, 1'b0); bstop();
      chk("R4 R5", d, VEC[i][7:0]);
    end

    // R7, R8: sequential read across 0x1FF
    sel_read(1'b1, 8'hFE, "R7");
    rbyte(d, 1'b1); chk("R7", d, 8'h11);
    rbyte(d, 1'b1); chk("R7", d, 8'h22);
    rbyte(d, 1'b1); chk("R8", d, 8'h33);
    rbyte(d, 1'b0); chk("R8", d, 8'h44);
    bstop();

    // R6: current-address read continues after last byte
    sel_read(1'b0, 8'h00, "R6"); rbyte(d, 1'b0); bstop();
    chk("R6", d, 8'h33);
    bstart(); wbyte(sa(1'b0, 1'b1), a); chk("R6", a, 1);
    rbyte(d, 1'b0); bstop(); chk("R6", d, 8'h44);

    // R3: multi-byte write with increment
    bstart(); wbyte(sa(1'b0, 1'b0), a); wbyte(8'h40, a);
    wbyte(8'h01, a); chk("R3", a, 1);
    wbyte(8'h02, a); chk("R3", a, 1);
    wbyte(8'h03, a); chk("R3", a, 1);
    bstop();
    sel_read(1'b0, 8'h40, "R3");
    rbyte(d, 1'b1); chk("R3", d, 8'h01);
    rbyte(d, 1'b1); chk("R3", d, 8'h02);
    rbyte(d, 1'b0); chk("R3", d, 8'h03);
    bstop();

    // R2: wrong device code is ignored
    bstart(); wbyte(8'hB0, a); chk("R2", a, 0);
    wbyte(8'h40, a); chk("R2", a, 0);
    wbyte(8'hEE, a); chk("R2", a, 0);
    bstop();
    bstart(); wbyte(8'h01, a); chk("R2", a, 0);
    rbits(d); bstop(); chk("R2", d, 8'hFF);
    sel_read(1'b0, 8'h40, "R2"); rbyte(d, 1'b0); bstop();
    chk("R2", d, 8'h01);

    // R9: NACK then START
    sel_read(1'b0, 8'h40, "R9"); rbyte(d, 1'b0);
    bstart(); chk("R9", sda_oe, 0);
    wbyte(sa(1'b0, 1'b1), a); chk("R9", a, 1);
    rbyte(d, 1'b0); bstop(); chk("R9", d, 8'h02);

    // R9: STOP in the 9th clock
    sel_read(1'b0, 8'h40, "R9"); rbits(d); chk("R9", d, 8'h01);
    bstop(); chk("R9", sda_oe, 0);
    bstart(); wbyte(sa(1'b0, 1'b1), a); rbyte(d, 1'b0); bstop();
    chk("R9", d, 8'h02);

    // R9: START in the 9th clock
    sel_read(1'b0, 8'h40, "R9"); rbits(d); chk("R9", d, 8'h01);
    bstart(); chk("R9", sda_oe, 0);
    wbyte(sa(1'b0, 1'b1), a); chk("R9", a, 1);
    rbyte(d, 1'b0); bstop(); chk("R9", d, 8'h02);

    // R11: STOP halfway through a data byte discards it
    bstart(); wbyte(sa(1'b0, 1'b0), a); wbyte(8'h42, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bstop(); chk("R11", sda_oe, 0);
    sel_read(1'b0, 8'h42, "R11"); rbyte(d, 1'b0); bstop();
    chk("R11", d, 8'h03);

    chk("R10", r10_viol[15:0], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule